// File: doc/BRIEF.md
# Two-Thread Partitioned Resource Allocator

This block sits between a shared micro-op queue and an out-of-order backend that runs two hardware threads. Each thread offers at most one opaque micro-op per cycle on its own valid/ready lane. The micro-op carries two request flags: it may need a rename register, a load/store slot, both, or neither. In any one cycle the allocator serves exactly one thread. It grants that micro-op the entries it asked for and reports the grant, registered, one cycle later with the thread tag and the allocated indices.

Both the register pool and the load/store pool are cut into two equal, fixed halves, one per thread. Each half is tracked by a credit counter and an allocation pointer, so a thread only ever receives indices from its own half. When both threads are eligible, service alternates. When only one thread is eligible, because the other is idle or has run dry on a resource it needs, that thread takes every cycle. Release pulses from retirement give one credit back per pool per thread. Entries are returned in the order they were handed out.

Top module: `dual_thread_alloc`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all credits are full (NUM_REG/2 register and NUM_LSQ/2 load/store credits per thread), `uop_ready` is 0 during reset, and `gnt_valid` is 0. The first cycle in which both threads are eligible is given to thread 0.
- R2: At most one bit of `uop_ready` is high in any cycle, and a ready bit is only high for a thread whose `uop_valid` bit is high. A thread is eligible when it is valid and has a credit for every resource its micro-op requests.
- R3: When both threads are eligible, the thread not served in the most recent serving cycle is chosen. An eligible thread never waits two cycles in a row.
- R4: When exactly one thread is eligible, it is served in that cycle.
- R5: A thread whose micro-op needs a register (or load/store slot) while its own credit for that pool is zero is not served. The other thread is then served in every cycle in which it is eligible.
- R6: A granted register index lies in [tid*NUM_REG/2, (tid+1)*NUM_REG/2), and a granted load/store index lies in [tid*NUM_LSQ/2, (tid+1)*NUM_LSQ/2). Within a half, indices are handed out in ascending order and wrap back to the half's base. An index output whose resource was not requested reads 0.
- R7: One cycle after a handshake (`uop_valid[t] & uop_ready[t]`), `gnt_valid` is 1 with `gnt_tid`=t (0 or 1), the thread's payload, and its two request flags. After a cycle with no handshake, `gnt_valid` is 0.
- R8: A release pulse returns one credit to the named thread's pool, and that credit can be used in the next cycle. A grant and a release on the same pool in the same cycle leave the count unchanged.
- R9: A release to a pool that already holds all its credits, with no grant from that pool in the same cycle, is ignored. Afterwards the thread still receives exactly NUM_REG/2 (or NUM_LSQ/2) grants before it runs dry.
- R10: A micro-op that requests neither resource is eligible whenever it is valid, even when the thread's credits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| uop_valid | input | 2 | Per-thread micro-op offered (bit t = thread t) |
| uop_need_reg | input | 2 | Per-thread: micro-op needs a rename register |
| uop_need_mem | input | 2 | Per-thread: micro-op needs a load/store slot |
| uop0_payload | input | PAYLOAD_W | Opaque micro-op of thread 0 |
| uop1_payload | input | PAYLOAD_W | Opaque micro-op of thread 1 |
| uop_ready | output | 2 | Per-thread: micro-op accepted this cycle |
| rel_reg | input | 2 | Per-thread: return one register credit |
| rel_mem | input | 2 | Per-thread: return one load/store credit |
| gnt_valid | output | 1 | Grant record valid |
| gnt_tid | output | 1 | Thread of the granted micro-op |
| gnt_payload | output | PAYLOAD_W | Payload of the granted micro-op |
| gnt_reg_used | output | 1 | A register was allocated |
| gnt_reg_idx | output | $clog2(NUM_REG) | Allocated register index |
| gnt_mem_used | output | 1 | A load/store slot was allocated |
| gnt_mem_idx | output | $clog2(NUM_LSQ) | Allocated load/store index |

## Verification
Directed sequences cover several cases. Two always-valid threads with no resource needs separate strict alternation from a fixed priority. A lone thread separates idle-skip from blind toggling. Draining one thread's register half while the other stays light shows that exhaustion hands every cycle to the neighbour. Releases aimed at a full pool, and releases that coincide with grants, show whether credits are lost or invented. A long random phase mixes valid, need and release bits with a fixed seed to hit wrap-around of both halves' pointers under contested arbitration.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    // Thread identifier used by the arbiter and grant record.
    typedef enum logic {
        THR_ZERO = 1'b0,
        THR_ONE  = 1'b1
    } thr_id_e;

    localparam int NUM_THREADS = 2;

    // Arbiter state: which thread was served most recently.
    typedef struct packed {
        thr_id_e last;
    } arb_state_t;

endpackage

// File: rtl/alloc_credit_ring.sv
// One thread's half of one resource pool: a credit counter plus an
// in-order allocation pointer that wraps inside the half.
module alloc_credit_ring #(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          give,
    output logic          avail,
    output logic [IW-1:0] head,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] ptr;
    } ring_t;

    localparam logic [CW-1:0] FULL     = CW'(DEPTH);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    ring_t ring_d, ring_q;
    logic  take_ok;
    logic  give_ok;

    always_comb begin
        ring_d  = ring_q;
        take_ok = take && (ring_q.cnt != '0);
        give_ok = give && ((ring_q.cnt != FULL) || take_ok);

        if (take_ok) begin
            ring_d.ptr = (ring_q.ptr == LAST_IDX) ? '0 : ring_q.ptr + 1'b1;
        end

        case ({take_ok, give_ok})
            2'b10:   ring_d.cnt = ring_q.cnt - 1'b1;
            2'b01:   ring_d.cnt = ring_q.cnt + 1'b1;
            default: ring_d.cnt = ring_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q.cnt <= FULL;
            ring_q.ptr <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign avail = (ring_q.cnt != '0);
    assign head  = ring_q.ptr;
    assign count = ring_q.cnt;

endmodule

// File: rtl/alloc_thread_arb.sv
// Picks one of two eligible threads, alternating under contention.
module alloc_thread_arb
    import alloc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] elig,
    output logic       sel_valid,
    output thr_id_e    sel_tid
);

    arb_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        sel_valid = |elig;
        unique case (elig)
            2'b11:   sel_tid = (st_q.last == THR_ZERO) ? THR_ONE : THR_ZERO;
            2'b10:   sel_tid = THR_ONE;
            default: sel_tid = THR_ZERO;
        endcase
        if (sel_valid) begin
            st_d.last = sel_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.last <= THR_ONE;   // next contested cycle goes to thread 0
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dual_thread_alloc.sv
module dual_thread_alloc
    import alloc_pkg::*;
#(
    parameter  int NUM_REG   = 8,
    parameter  int NUM_LSQ   = 4,
    parameter  int PAYLOAD_W = 12,
    localparam int REG_HALF  = NUM_REG / 2,
    localparam int LSQ_HALF  = NUM_LSQ / 2,
    localparam int RIW       = $clog2(NUM_REG),
    localparam int MIW       = $clog2(NUM_LSQ),
    localparam int RHW       = (REG_HALF > 1) ? $clog2(REG_HALF) : 1,
    localparam int MHW       = (LSQ_HALF > 1) ? $clog2(LSQ_HALF) : 1,
    localparam int RCW       = $clog2(REG_HALF + 1),
    localparam int MCW       = $clog2(LSQ_HALF + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           uop_valid,
    input  logic [1:0]           uop_need_reg,
    input  logic [1:0]           uop_need_mem,
    input  logic [PAYLOAD_W-1:0] uop0_payload,
    input  logic [PAYLOAD_W-1:0] uop1_payload,
    output logic [1:0]           uop_ready,
    input  logic [1:0]           rel_reg,
    input  logic [1:0]           rel_mem,
    output logic                 gnt_valid,
    output logic                 gnt_tid,
    output logic [PAYLOAD_W-1:0] gnt_payload,
    output logic                 gnt_reg_used,
    output logic [RIW-1:0]       gnt_reg_idx,
    output logic                 gnt_mem_used,
    output logic [MIW-1:0]       gnt_mem_idx
);

    typedef struct packed {
        logic                 valid;
        logic                 tid;
        logic [PAYLOAD_W-1:0] payload;
        logic                 reg_used;
        logic [RIW-1:0]       reg_idx;
        logic                 mem_used;
        logic [MIW-1:0]       mem_idx;
    } grant_t;

    logic [1:0]          reg_avail, mem_avail;
    logic [1:0]          take_reg, take_mem;
    logic [1:0]          elig;
    logic [1:0][RHW-1:0] reg_head;
    logic [1:0][MHW-1:0] mem_head;
    logic [1:0][RCW-1:0] reg_cnt;
    logic [1:0][MCW-1:0] mem_cnt;
    logic                sel_valid;
    thr_id_e             sel_tid;
    grant_t              gnt_d, gnt_q;

    // Per-thread credit pools, one ring per resource half.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign elig[t] = !rst && uop_valid[t]
                       && (!uop_need_reg[t] || reg_avail[t])
                       && (!uop_need_mem[t] || mem_avail[t]);

        assign take_reg[t] = sel_valid && (sel_tid == thr_id_e'(t)) && uop_need_reg[t];
        assign take_mem[t] = sel_valid && (sel_tid == thr_id_e'(t)) && uop_need_mem[t];
        assign uop_ready[t] = sel_valid && (sel_tid == thr_id_e'(t));

        alloc_credit_ring #(.DEPTH(REG_HALF)) i_reg_ring (
            .clk   (clk),
            .rst   (rst),
            .take  (take_reg[t]),
            .give  (rel_reg[t]),
            .avail (reg_avail[t]),
            .head  (reg_head[t]),
            .count (reg_cnt[t])
        );

        alloc_credit_ring #(.DEPTH(LSQ_HALF)) i_mem_ring (
            .clk   (clk),
            .rst   (rst),
            .take  (take_mem[t]),
            .give  (rel_mem[t]),
            .avail (mem_avail[t]),
            .head  (mem_head[t]),
            .count (mem_cnt[t])
        );
    end

    alloc_thread_arb i_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .sel_valid (sel_valid),
        .sel_tid   (sel_tid)
    );

    // Build the grant record for the selected thread.
    always_comb begin
        logic           s;
        logic [RIW-1:0] rbase;
        logic [MIW-1:0] mbase;
        s       = (sel_tid == THR_ONE);
        rbase   = s ? RIW'(REG_HALF) : '0;
        mbase   = s ? MIW'(LSQ_HALF) : '0;
        gnt_d   = '0;
        if (sel_valid) begin
            gnt_d.valid    = 1'b1;
            gnt_d.tid      = s;
            gnt_d.payload  = s ? uop1_payload : uop0_payload;
            gnt_d.reg_used = uop_need_reg[s];
            gnt_d.mem_used = uop_need_mem[s];
            if (uop_need_reg[s]) begin
                gnt_d.reg_idx = rbase + RIW'(reg_head[s]);
            end
            if (uop_need_mem[s]) begin
                gnt_d.mem_idx = mbase + MIW'(mem_head[s]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
        end else begin
            gnt_q <= gnt_d;
        end
    end

    assign gnt_valid    = gnt_q.valid;
    assign gnt_tid      = gnt_q.tid;
    assign gnt_payload  = gnt_q.payload;
    assign gnt_reg_used = gnt_q.reg_used;
    assign gnt_reg_idx  = gnt_q.reg_idx;
    assign gnt_mem_used = gnt_q.mem_used;
    assign gnt_mem_idx  = gnt_q.mem_idx;

endmodule

// File: rtl/dual_thread_alloc_chk.sv
module dual_thread_alloc_chk #(
    parameter  int NUM_REG  = 8,
    parameter  int NUM_LSQ  = 4,
    localparam int REG_HALF = NUM_REG / 2,
    localparam int LSQ_HALF = NUM_LSQ / 2,
    localparam int RIW      = $clog2(NUM_REG),
    localparam int MIW      = $clog2(NUM_LSQ),
    localparam int RCW      = $clog2(REG_HALF + 1),
    localparam int MCW      = $clog2(LSQ_HALF + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          uop_valid,
    input logic [1:0]          uop_need_reg,
    input logic [1:0]          uop_need_mem,
    input logic [1:0]          uop_ready,
    input logic                gnt_valid,
    input logic                gnt_tid,
    input logic                gnt_reg_used,
    input logic [RIW-1:0]      gnt_reg_idx,
    input logic                gnt_mem_used,
    input logic [MIW-1:0]      gnt_mem_idx,
    input logic [1:0][RCW-1:0] reg_cnt,
    input logic [1:0][MCW-1:0] mem_cnt
);

    AST_ONE_READY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(uop_ready));                                            // R2
    AST_READY_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        (uop_ready & ~uop_valid) == 2'b00);                              // R2
    AST_ALTERNATE_TO_ONE: assert property (@(posedge clk) disable iff (rst)
        ($past(uop_ready[0]) && uop_valid == 2'b11 && !uop_need_reg[1] && !uop_need_mem[1])
        |-> uop_ready[1]);                                               // R3
    AST_ALTERNATE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(uop_ready[1]) && uop_valid == 2'b11 && !uop_need_reg[0] && !uop_need_mem[0])
        |-> uop_ready[0]);                                               // R3
    AST_SOLO_SERVED: assert property (@(posedge clk) disable iff (rst)
        (uop_valid == 2'b01 && uop_need_reg == 2'b00 && uop_need_mem == 2'b00)
        |-> uop_ready[0]);                                               // R4
    AST_REG_IN_HALF: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_reg_used)
        |-> ((32'(gnt_reg_idx) >= (gnt_tid ? REG_HALF : 0)) &&
             (32'(gnt_reg_idx) <  (gnt_tid ? NUM_REG : REG_HALF))));     // R6
    AST_MEM_IN_HALF: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_mem_used)
        |-> ((32'(gnt_mem_idx) >= (gnt_tid ? LSQ_HALF : 0)) &&
             (32'(gnt_mem_idx) <  (gnt_tid ? NUM_LSQ : LSQ_HALF))));     // R6
    AST_GNT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (|uop_ready) |=> (gnt_valid && gnt_tid == $past(uop_ready[1]))); // R7
    AST_NO_IDLE_GNT: assert property (@(posedge clk) disable iff (rst)
        !(|uop_ready) |=> !gnt_valid);                                   // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (32'(reg_cnt[0]) <= REG_HALF) && (32'(reg_cnt[1]) <= REG_HALF) &&
        (32'(mem_cnt[0]) <= LSQ_HALF) && (32'(mem_cnt[1]) <= LSQ_HALF)); // R9

endmodule

bind dual_thread_alloc dual_thread_alloc_chk #(
    .NUM_REG (NUM_REG),
    .NUM_LSQ (NUM_LSQ)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .uop_valid    (uop_valid),
    .uop_need_reg (uop_need_reg),
    .uop_need_mem (uop_need_mem),
    .uop_ready    (uop_ready),
    .gnt_valid    (gnt_valid),
    .gnt_tid      (gnt_tid),
    .gnt_reg_used (gnt_reg_used),
    .gnt_reg_idx  (gnt_reg_idx),
    .gnt_mem_used (gnt_mem_used),
    .gnt_mem_idx  (gnt_mem_idx),
    .reg_cnt      (reg_cnt),
    .mem_cnt      (mem_cnt)
);

// File: tb/test_dual_thread_alloc.sv
`timescale 1ns/1ps
module test_dual_thread_alloc;

    localparam int NUM_REG   = 8;
    localparam int NUM_LSQ   = 4;
    localparam int PAYLOAD_W = 12;
    localparam int RH        = NUM_REG / 2;
    localparam int MH        = NUM_LSQ / 2;
    localparam int RIW       = $clog2(NUM_REG);
    localparam int MIW       = $clog2(NUM_LSQ);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           uop_valid = '0, uop_need_reg = '0, uop_need_mem = '0;
    logic [PAYLOAD_W-1:0] uop0_payload = '0, uop1_payload = '0;
    logic [1:0]           uop_ready;
    logic [1:0]           rel_reg = '0, rel_mem = '0;
    logic                 gnt_valid, gnt_tid, gnt_reg_used, gnt_mem_used;
    logic [PAYLOAD_W-1:0] gnt_payload;
    logic [RIW-1:0]       gnt_reg_idx;
    logic [MIW-1:0]       gnt_mem_idx;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_thread_alloc #(.NUM_REG(NUM_REG), .NUM_LSQ(NUM_LSQ), .PAYLOAD_W(PAYLOAD_W)) i_dual_thread_alloc (
        .clk(clk), .rst(rst), .uop_valid(uop_valid), .uop_need_reg(uop_need_reg),
        .uop_need_mem(uop_need_mem), .uop0_payload(uop0_payload), .uop1_payload(uop1_payload),
        .uop_ready(uop_ready), .rel_reg(rel_reg), .rel_mem(rel_mem),
        .gnt_valid(gnt_valid), .gnt_tid(gnt_tid), .gnt_payload(gnt_payload),
        .gnt_reg_used(gnt_reg_used), .gnt_reg_idx(gnt_reg_idx),
        .gnt_mem_used(gnt_mem_used), .gnt_mem_idx(gnt_mem_idx));

    int n_chk = 0, n_fail = 0;
    int m_rc[2], m_rh[2], m_mc[2], m_mh[2], m_last;
    int waitc[2];
    bit done = 0;

    task automatic check(input string req, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < 2; t++) begin
            m_rc[t] = RH; m_rh[t] = 0; m_mc[t] = MH; m_mh[t] = 0; waitc[t] = 0;
        end
        m_last = 1;
    endtask

    function automatic bit m_elig(int t, logic [1:0] v, logic [1:0] nr, logic [1:0] nm);
        return v[t] && (!nr[t] || m_rc[t] > 0) && (!nm[t] || m_mc[t] > 0);
    endfunction

    // One cycle: drive at negedge, check ready before the edge, grant after it.
    task automatic step(input logic [1:0] v, input logic [1:0] nr, input logic [1:0] nm,
                        input logic [1:0] rr, input logic [1:0] rm, input string tag);
        bit e0, e1, sv; int s; string rq;
        logic [PAYLOAD_W-1:0] p0, p1;
        int exp_ridx, exp_midx;
        p0 = PAYLOAD_W'($urandom); p1 = PAYLOAD_W'($urandom);
        uop_valid = v; uop_need_reg = nr; uop_need_mem = nm;
        uop0_payload = p0; uop1_payload = p1; rel_reg = rr; rel_mem = rm;
        e0 = m_elig(0, v, nr, nm); e1 = m_elig(1, v, nr, nm);
        sv = e0 | e1;
        s  = (e0 && e1) ? 1 - m_last : (e1 ? 1 : 0);
        if (tag != "") rq = tag;
        else if (e0 && e1) rq = "R3";
        else if (v == 2'b11 && sv) rq = "R5";
        else if (sv && !nr[s] && !nm[s]) rq = "R10";
        else rq = "R4";
        #1;
        check(rq, uop_ready, sv ? (2'b01 << s) : 2'b00, "uop_ready");
        // fairness: an eligible thread left waiting twice in a row
        for (int t = 0; t < 2; t++) begin
            if (m_elig(t, v, nr, nm) && !(sv && s == t)) waitc[t]++; else waitc[t] = 0;
            check("R3", waitc[t] > 1, 0, "eligible thread starved");
        end
        exp_ridx = (sv && nr[s]) ? s * RH + m_rh[s] : 0;
        exp_midx = (sv && nm[s]) ? s * MH + m_mh[s] : 0;
        // model update (R8, R9)
        for (int t = 0; t < 2; t++) begin
            bit tr, tm;
            tr = sv && s == t && nr[t];
            tm = sv && s == t && nm[t];
            if (tr) begin m_rc[t]--; m_rh[t] = (m_rh[t] + 1) % RH; end
            if (tm) begin m_mc[t]--; m_mh[t] = (m_mh[t] + 1) % MH; end
            if (rr[t] && (m_rc[t] < RH)) m_rc[t]++;
            if (rm[t] && (m_mc[t] < MH)) m_mc[t]++;
        end
        if (sv) m_last = s;
        @(posedge clk); #1;
        check("R7", gnt_valid, sv, "gnt_valid");
        if (sv) begin
            check("R7", gnt_tid, s, "gnt_tid");
            check("R7", gnt_payload, s ? p1 : p0, "gnt_payload");
            check("R7", {gnt_reg_used, gnt_mem_used}, {nr[s], nm[s]}, "gnt flags");
            check("R6", gnt_reg_idx, exp_ridx, "gnt_reg_idx");
            check("R6", gnt_mem_idx, exp_midx, "gnt_mem_idx");
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; uop_valid = 2'b11; uop_need_reg = '0; uop_need_mem = '0; rel_reg = '0; rel_mem = '0;
        @(negedge clk); @(negedge clk);
        check("R1", uop_ready, 0, "ready in reset");
        check("R1", gnt_valid, 0, "gnt_valid in reset");
        rst = 0;
        model_reset();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        do_reset();
        // R1: first contested cycle goes to thread 0, then R3 alternation
        step(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R1");
        for (int i = 0; i < 4; i++) step(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R3");
        // R4: lone thread every cycle
        for (int i = 0; i < 3; i++) step(2'b10, 2'b10, 2'b00, 2'b00, 2'b00, "R4");
        // R5: drain thread 0 registers while thread 1 needs nothing
        do_reset();
        for (int i = 0; i < 12; i++) step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "");
        check("R5", m_rc[0], 0, "thread0 drained");
        // R10: no-need uop passes with zero credits
        step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, "R10");
        // R8: release lets the next cycle grant; grant+release nets zero
        step(2'b01, 2'b01, 2'b00, 2'b01, 2'b00, "R8");
        step(2'b01, 2'b01, 2'b00, 2'b01, 2'b00, "R8");
        step(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, "R8");
        step(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, "R8");
        // R9: releases to full pools ignored; exactly RH then MH grants
        do_reset();
        for (int i = 0; i < 3; i++) step(2'b00, 2'b00, 2'b00, 2'b11, 2'b11, "R9");
        for (int i = 0; i < RH + 1; i++) step(2'b10, 2'b10, 2'b00, 2'b00, 2'b00, "R9");
        for (int i = 0; i < MH + 1; i++) step(2'b01, 2'b00, 2'b01, 2'b00, 2'b00, "R9");
        // random phase
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] rr, rm;
            rr = 2'($urandom); rm = 2'($urandom);
            if ($urandom_range(3) != 0) begin rr = rr & 2'($urandom); rm = rm & 2'($urandom); end
            step(2'($urandom) | 2'($urandom), 2'($urandom), 2'($urandom), rr, rm, "");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule